// File: doc/BRIEF.md
# Fixed and Programmable Interval Timers

This block holds two interval timers for an embedded processor core. Both advance only in cycles where the time-base tick input is high. They share one control register and one status register. The fixed timer raises a status flag at a regular power-of-two interval of ticks. A control field chooses that interval. The programmable timer counts down from a value that software loads. It can stop at the end of the count or reload itself and run again.

Software reaches the block through one register port. The port writes on `wr_en` and reads combinationally through `rd_data`. The address selects one of three registers:

- Address 0 is the countdown. A write loads a new value. A read returns the count that remains.
- Address 1 is the control register.
- Address 2 is the status register. Its flags are cleared by writing 1 to them.

Each timer drives its own interrupt request. The request is high while the timer's status flag and its enable bit are both set.

Top module: `interval_timers`

## Requirements
- R1: After reset the remaining count, the control register and the status register all read 0, and both interrupt outputs are low.
- R2: Control bits 25:24 choose the fixed interval: 2^9, 2^13, 2^17 or 2^21 ticks for the values 0, 1, 2 and 3. Ticks are counted from reset or from the previous fixed expiry.
- R3: Each fixed expiry sets status bit 26. The fixed timer then starts a fresh interval of the selected length.
- R4: `fix_irq` is high exactly while status bit 26 and control bit 23 are both 1.
- R5: A write to address 0 loads the written value as the remaining count. The countdown runs when that value is greater than 1 and control bit 26 is 1. A running count drops by one on each tick and holds in cycles without a tick. A read of address 0 returns the remaining count.
- R6: A load of 0 or 1, or any load while control bit 26 is 0, leaves the countdown stopped. The loaded value then stays in the count whatever ticks arrive, and status bit 27 is not set.
- R7: A countdown loaded with N expires on its N-th tick and sets status bit 27. `pit_irq` is high exactly while status bit 27 and control bit 26 are both 1.
- R8: If control bit 22 is 1, an expiry reloads the last loaded value on the same tick, so the next expiry follows exactly N ticks later. If bit 22 is 0, the count goes to 0 and stops.
- R9: Writing a 1 to status bit 26 or 27 clears that flag. Writing a 0 to a flag leaves it unchanged.
- R10: The control register reads back only bits 26 to 22, and the status register reads back only bits 27 and 26. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base tick enable; both timers advance only on cycles where it is high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 countdown, 1 control, 2 status |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| fix_irq | output | 1 | Fixed-interval interrupt request |
| pit_irq | output | 1 | Programmable-timer interrupt request |

## Verification
Every tick and every register write takes effect at the next rising clock edge. The interrupts and the read data are combinational from the registers, so each result can be seen in the same cycle as that edge. The bench changes its inputs and samples the outputs on falling edges. It delivers an exact number of ticks with no tick during register accesses, so an expiry is checked one tick before it is due (flag still clear) and on the tick where it is due (flag set). Reload periods and the hold of the count in cycles without a tick are checked by counting ticks the same way.

// File: rtl/interval_timers.sv
module interval_timers #(
  parameter int DW       = 32,
  parameter int FIX_BASE = 9,
  parameter int FIX_STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          fix_irq,
  output logic          pit_irq
);
  localparam int FIX_W   = FIX_BASE + 3 * FIX_STEP;
  localparam int B_PIE   = 26;
  localparam int B_FSEL  = 24;
  localparam int B_FIE   = 23;
  localparam int B_ARE   = 22;
  localparam int B_SPIT  = 27;
  localparam int B_SFIT  = 26;
  localparam logic [1:0] A_LOAD = 2'd0;
  localparam logic [1:0] A_CTL  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  logic             ctl_pie, ctl_fie, ctl_are;
  logic [1:0]       ctl_fsel;
  logic             st_pit, st_fit;
  logic [FIX_W-1:0] fix_cnt, fix_lim;
  logic [DW-1:0]    pit_cnt, pit_rld;
  logic             pit_run;
  logic             ld_wr, ctl_wr, st_wr, fix_hit, pit_hit;

  assign ld_wr   = wr_en && (addr == A_LOAD);
  assign ctl_wr  = wr_en && (addr == A_CTL);
  assign st_wr   = wr_en && (addr == A_STAT);
  assign fix_lim = {FIX_W{1'b1}} >> (FIX_STEP * (3 - int'(ctl_fsel)));
  assign fix_hit = tick && (fix_cnt >= fix_lim);
  assign pit_hit = tick && pit_run && (pit_cnt == DW'(1)) && !ld_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_pie  <= 1'b0;
      ctl_fie  <= 1'b0;
      ctl_are  <= 1'b0;
      ctl_fsel <= 2'd0;
    end else if (ctl_wr) begin
      ctl_pie  <= wr_data[B_PIE];
      ctl_fie  <= wr_data[B_FIE];
      ctl_are  <= wr_data[B_ARE];
      ctl_fsel <= wr_data[B_FSEL +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fix_cnt <= '0;
    else if (fix_hit) fix_cnt <= '0;
    else if (tick)    fix_cnt <= fix_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pit_cnt <= '0;
      pit_rld <= '0;
      pit_run <= 1'b0;
    end else if (ld_wr) begin
      pit_cnt <= wr_data;
      pit_rld <= wr_data;
      pit_run <= (wr_data > DW'(1)) && ctl_pie;
    end else if (tick && pit_run) begin
      if (pit_cnt == DW'(1)) begin
        if (ctl_are) pit_cnt <= pit_rld;
        else begin
          pit_cnt <= '0;
          pit_run <= 1'b0;
        end
      end else begin
        pit_cnt <= pit_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_fit <= 1'b0;
      st_pit <= 1'b0;
    end else begin
      st_fit <= fix_hit | (st_fit & ~(st_wr & wr_data[B_SFIT]));
      st_pit <= pit_hit | (st_pit & ~(st_wr & wr_data[B_SPIT]));
    end
  end

  assign fix_irq = st_fit & ctl_fie;
  assign pit_irq = st_pit & ctl_pie;

  always_comb begin
    rd_data = '0;
    case (addr)
      A_LOAD: rd_data = pit_cnt;
      A_CTL: begin
        rd_data[B_PIE]       = ctl_pie;
        rd_data[B_FSEL +: 2] = ctl_fsel;
        rd_data[B_FIE]       = ctl_fie;
        rd_data[B_ARE]       = ctl_are;
      end
      A_STAT: begin
        rd_data[B_SPIT] = st_pit;
        rd_data[B_SFIT] = st_fit;
      end
      default: rd_data = '0;
    endcase
  end

  AST_FIT_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    st_fit && !(st_wr && wr_data[B_SFIT]) |=> st_fit); // R9
  AST_PIT_SMALL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr && (wr_data <= DW'(1)) |=> !pit_run && !st_pit); // R6
  AST_PIT_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    pit_run && tick && !ld_wr && (pit_cnt > DW'(1)) |=> pit_cnt == $past(pit_cnt) - 1'b1); // R5
  AST_PIT_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    pit_run && tick && !ld_wr && (pit_cnt == DW'(1)) && ctl_are
    |=> pit_run && st_pit && (pit_cnt == $past(pit_rld))); // R8
  AST_PIT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !ld_wr |=> $stable(pit_cnt)); // R5
  AST_FIT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fix_hit |=> fix_cnt == '0 && st_fit); // R3
endmodule

// File: tb/tb_interval_timers.sv
module tb_interval_timers;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        fix_irq, pit_irq;
  int          total = 0;
  int          bad = 0;

  interval_timers dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .fix_irq(fix_irq), .pit_irq(pit_irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); check("R1 count", v, 32'h0);
    rd(2'd1, v); check("R1 control", v, 32'h0);
    rd(2'd2, v); check("R1 status", v, 32'h0);
    check("R1 irqs", {30'd0, fix_irq, pit_irq}, 32'h0);
  endtask

  task automatic t_fixed();
    logic [31:0] v;
    wr(2'd1, 32'h0080_0000);
    ticks(511); rd(2'd2, v); check("R2 sel0 before", v, 32'h0);
    ticks(1);   rd(2'd2, v); check("R2 sel0 at 512", v, 32'h0400_0000);
    check("R4 fix_irq on", {31'd0, fix_irq}, 32'h1);
    wr(2'd2, 32'h0400_0000); rd(2'd2, v); check("R9 clear fit", v, 32'h0);
    ticks(511); rd(2'd2, v); check("R3 rearm before", v, 32'h0);
    ticks(1);   rd(2'd2, v); check("R3 rearm at 512", v, 32'h0400_0000);
    wr(2'd2, 32'h0400_0000);
    wr(2'd1, 32'h0100_0000);
    ticks(8191); rd(2'd2, v); check("R2 sel1 before", v, 32'h0);
    ticks(1);    rd(2'd2, v); check("R2 sel1 at 8192", v, 32'h0400_0000);
    check("R4 fix_irq masked", {31'd0, fix_irq}, 32'h0);
    wr(2'd2, 32'h0); rd(2'd2, v); check("R9 write zero keeps", v, 32'h0400_0000);
    wr(2'd1, 32'h0180_0000);
    check("R4 fix_irq after enable", {31'd0, fix_irq}, 32'h1);
    wr(2'd2, 32'h0400_0000);
    check("R4 fix_irq after clear", {31'd0, fix_irq}, 32'h0);
    wr(2'd1, 32'h0200_0000);
    ticks(131071); rd(2'd2, v); check("R2 sel2 before", v, 32'h0);
    ticks(1);      rd(2'd2, v); check("R2 sel2 at 131072", v, 32'h0400_0000);
    wr(2'd2, 32'h0400_0000);
  endtask

  task automatic t_pit_oneshot();
    logic [31:0] v;
    wr(2'd1, 32'h0400_0000);
    wr(2'd0, 32'd5);
    rd(2'd0, v); check("R5 loaded", v, 32'd5);
    ticks(1); rd(2'd0, v); check("R5 one tick", v, 32'd4);
    repeat (3) @(negedge clk);
    rd(2'd0, v); check("R5 holds without tick", v, 32'd4);
    ticks(3); rd(2'd0, v); check("R5 count at 1", v, 32'd1);
    rd(2'd2, v); check("R7 not yet", v & 32'h0800_0000, 32'h0);
    ticks(1); rd(2'd2, v); check("R7 expiry flag", v & 32'h0800_0000, 32'h0800_0000);
    check("R7 pit_irq on", {31'd0, pit_irq}, 32'h1);
    rd(2'd0, v); check("R8 one-shot ends at 0", v, 32'd0);
    ticks(2); rd(2'd0, v); check("R8 one-shot stays stopped", v, 32'd0);
    wr(2'd2, 32'h0C00_0000); rd(2'd2, v); check("R9 clear pit", v, 32'h0);
    check("R7 pit_irq off", {31'd0, pit_irq}, 32'h0);
  endtask

  task automatic t_pit_auto();
    logic [31:0] v;
    wr(2'd1, 32'h0440_0000);
    wr(2'd0, 32'd3);
    ticks(3); rd(2'd2, v); check("R8 first expiry", v & 32'h0800_0000, 32'h0800_0000);
    rd(2'd0, v); check("R8 reloaded", v, 32'd3);
    wr(2'd2, 32'h0800_0000);
    ticks(2); rd(2'd0, v); check("R8 second count", v, 32'd1);
    rd(2'd2, v); check("R8 no early expiry", v & 32'h0800_0000, 32'h0);
    ticks(1); rd(2'd2, v); check("R8 second expiry", v & 32'h0800_0000, 32'h0800_0000);
    wr(2'd1, 32'h0040_0000);
    check("R7 pit_irq masked", {31'd0, pit_irq}, 32'h0);
    wr(2'd2, 32'h0C00_0000);
  endtask

  task automatic t_pit_stopped();
    logic [31:0] v;
    wr(2'd1, 32'h0440_0000);
    wr(2'd0, 32'd1);
    ticks(4); rd(2'd0, v); check("R6 load 1 holds", v, 32'd1);
    rd(2'd2, v); check("R6 load 1 no flag", v & 32'h0800_0000, 32'h0);
    wr(2'd0, 32'd0);
    ticks(4); rd(2'd0, v); check("R6 load 0 holds", v, 32'd0);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'd7);
    ticks(3); rd(2'd0, v); check("R6 disabled holds", v, 32'd7);
    rd(2'd2, v); check("R6 disabled no flag", v & 32'h0800_0000, 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R10 control mask", v, 32'h07C0_0000);
    wr(2'd1, 32'h0);
    rd(2'd1, v); check("R10 control cleared", v, 32'h0);
    rd(2'd2, v); check("R10 status mask", v & 32'hF3FF_FFFF, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_pit_oneshot();
    t_pit_auto();
    t_pit_stopped();
    t_readback();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule